// File: doc/BRIEF.md
# Masked Compare-Capture Timer Unit

This block is a general-purpose timer built around a free-running time base counter. The counter advances by one on every clock, wraps to zero past its top value, and can be loaded from a small synchronous register port. Five capture channels watch external inputs. When a channel is enabled, a rising edge on its input stores the current count in that channel's capture register.

Five compare channels each hold a compare value and a bit-mask. A compare channel matches when every counter bit left unmasked equals the same bit of its compare value. Each of the ten channels owns a sticky status bit and a dedicated interrupt line. The line is gated by an enable bit and a mask bit.

Two reset inputs clear different sets of state. The unit reset brings the block to a stable state and leaves the programmed channel setup untouched. The counter reset clears only the counter. Software reads and writes the registers through a word-addressed port with combinational read data.

Top module: `mcct_top`

## Requirements
- R1: The counter (word address 0x00) increases by one on every clock, wraps from 0xFFFFFFFF to 0x00000000, and takes the written value on the clock of a write to address 0x00, counting on from it on later clocks.
- R2: Compare channel j matches when (count XOR compare_j) AND NOT mask_j is zero. A mask bit of 1 removes that counter bit from the comparison. Compare j is at address 0x08+j, its mask at 0x10+j, and its status bit is bit 16+j.
- R3: A compare channel sets its status bit only on the clock where its match starts. A match that persists does not set the bit again after software clears it.
- R4: Capture channel i (capture register at address 0x18+i, read-only; status bit i) passes its input through two flops. If its bit in the capture-enable register (address 0x01, bit i) is 1, a rising edge stores the count and sets status bit i. If the input rises just after the clock on which the count became V, the capture register receives V+2.
- R5: When the capture-enable bit of a channel is 0, edges on its input change neither its capture register nor its status bit.
- R6: Status bits (address 0x03) stay set until software writes 1 to them. Writing 0 leaves a bit unchanged.
- R7: Each interrupt line is high exactly when its status bit is 1, its enable bit (address 0x04, same bit position) is 1, and its mask bit (address 0x02, same bit position) is 0.
- R8: The unit reset sets the counter to 0x00000000, the capture-enable register to 0x00000000 and the interrupt-mask register to 0xF800F800.
- R9: The unit reset leaves the interrupt-enable, status, compare, compare-mask and capture registers unchanged.
- R10: The counter reset clears the counter to zero and changes no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| unit_rst | input | 1 | Synchronous unit reset, active high |
| tbc_rst | input | 1 | Synchronous counter-only reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| cap_in | input | 5 | Asynchronous capture inputs, one per capture channel |
| irq_cap | output | 5 | Capture interrupt lines |
| irq_cmp | output | 5 | Compare interrupt lines |

## Verification
The compare logic is tested with three kinds of mask on the same compare value. A mask on the upper half must match while an unmasked twin stays quiet, which separates masked matching from exact matching. With no mask, both channels must fire. A mask on the low byte opens a 256-cycle match window, and a status clear inside that window shows that a persistent match does not fire again. Capture is tested with an enabled edge, checked against an exact count value, and with a disabled edge that must leave the register and the status bit alone. Finally, each reset is applied after the same registers hold known values, so the two cleared sets can be told apart.

// File: rtl/mcct_pkg.sv
package mcct_pkg;
   localparam int ADDR_W = 6;
   localparam int CH_WIN = 8;
   typedef logic [ADDR_W-1:0] addr_t;

   localparam addr_t A_TBC      = 6'h00;
   localparam addr_t A_CAPEN    = 6'h01;
   localparam addr_t A_IMASK    = 6'h02;
   localparam addr_t A_ISTS     = 6'h03;
   localparam addr_t A_IEN      = 6'h04;
   localparam addr_t A_CMP_BASE = 6'h08;
   localparam addr_t A_MSK_BASE = 6'h10;
   localparam addr_t A_CAP_BASE = 6'h18;
endpackage

// File: rtl/mcct_timebase.sv
module mcct_timebase #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (clr)       count <= '0;
      else if (load) count <= load_val;
      else           count <= count + 1'b1;
   end
endmodule

// File: rtl/mcct_capture_chan.sv
module mcct_capture_chan #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         cap_in,
   input  logic         enable,
   input  logic [W-1:0] tbc,
   output logic [W-1:0] cap_q,
   output logic         hit
);
   logic sync_out;
   logic prev_q;

   if (STAGES == 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk) s_q <= cap_in;
      assign sync_out = s_q;
   end else begin : g_chain
      logic [STAGES-1:0] s_q;
      always_ff @(posedge clk) s_q <= {s_q[STAGES-2:0], cap_in};
      assign sync_out = s_q[STAGES-1];
   end

   assign hit = enable & sync_out & ~prev_q;

   always_ff @(posedge clk) begin
      prev_q <= sync_out;
      if (hit) cap_q <= tbc;
   end
endmodule

// File: rtl/mcct_compare_chan.sv
module mcct_compare_chan #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         cmp_we,
   input  logic         msk_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] tbc,
   output logic [W-1:0] cmp_q,
   output logic [W-1:0] msk_q,
   output logic         hit
);
   logic match;
   logic match_q;

   assign match = ~|((tbc ^ cmp_q) & ~msk_q);
   assign hit   = match & ~match_q;

   always_ff @(posedge clk) begin
      if (cmp_we) cmp_q <= wdata;
      if (msk_we) msk_q <= wdata;
      match_q <= match;
   end
endmodule

// File: rtl/mcct_top.sv
module mcct_top
   import mcct_pkg::*;
#(
   parameter int                TBC_W       = 32,
   parameter int                N_CAP       = 5,
   parameter int                N_CMP       = 5,
   parameter int                CMP_BIT0    = 16,
   parameter int                SYNC_STAGES = 2,
   parameter logic [TBC_W-1:0]  IMASK_RST   = 32'hF800F800
) (
   input  logic               clk,
   input  logic               unit_rst,
   input  logic               tbc_rst,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [TBC_W-1:0]   reg_wdata,
   output logic [TBC_W-1:0]   reg_rdata,
   input  logic [N_CAP-1:0]   cap_in,
   output logic [N_CAP-1:0]   irq_cap,
   output logic [N_CMP-1:0]   irq_cmp
);
   localparam int REG_W = TBC_W;
   localparam logic [REG_W-1:0] CAP_BITS = REG_W'((64'd1 << N_CAP) - 64'd1);
   localparam logic [REG_W-1:0] CMP_BITS = REG_W'(((64'd1 << N_CMP) - 64'd1) << CMP_BIT0);
   localparam logic [REG_W-1:0] CH_BITS  = CAP_BITS | CMP_BITS;

   if (N_CAP < 1 || N_CAP > CH_WIN) begin : g_bad_ncap
      $error("N_CAP out of range");
   end
   if (N_CMP < 1 || N_CMP > CH_WIN) begin : g_bad_ncmp
      $error("N_CMP out of range");
   end
   if (CMP_BIT0 < N_CAP || CMP_BIT0 + N_CMP > REG_W) begin : g_bad_bits
      $error("status bit layout does not fit");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic [REG_W-1:0]              tbc_q;
   logic [N_CAP-1:0]              cap_en_q;
   logic [REG_W-1:0]              imask_q;
   logic [REG_W-1:0]              ien_q;
   logic [REG_W-1:0]              sts_q;
   logic [REG_W-1:0]              sts_set;
   logic [REG_W-1:0]              sts_clr;
   logic [N_CAP-1:0]              cap_hit;
   logic [N_CMP-1:0]              cmp_hit;
   logic [N_CMP-1:0]              cmp_we;
   logic [N_CMP-1:0]              msk_we;
   logic [N_CAP-1:0][REG_W-1:0]   cap_val;
   logic [N_CMP-1:0][REG_W-1:0]   cmp_val;
   logic [N_CMP-1:0][REG_W-1:0]   msk_val;

   mcct_timebase #(.W(REG_W)) u_tb (
      .clk      (clk),
      .clr      (unit_rst | tbc_rst),
      .load     (reg_we && reg_addr == A_TBC),
      .load_val (reg_wdata),
      .count    (tbc_q)
   );

   for (genvar i = 0; i < N_CAP; i++) begin : gen_cap
      mcct_capture_chan #(.W(REG_W), .STAGES(SYNC_STAGES)) u_cap (
         .clk    (clk),
         .cap_in (cap_in[i]),
         .enable (cap_en_q[i]),
         .tbc    (tbc_q),
         .cap_q  (cap_val[i]),
         .hit    (cap_hit[i])
      );
      assign irq_cap[i] = sts_q[i] & ien_q[i] & ~imask_q[i];
   end

   for (genvar j = 0; j < N_CMP; j++) begin : gen_cmp
      assign cmp_we[j] = reg_we && reg_addr == A_CMP_BASE + addr_t'(j);
      assign msk_we[j] = reg_we && reg_addr == A_MSK_BASE + addr_t'(j);
      mcct_compare_chan #(.W(REG_W)) u_cmp (
         .clk    (clk),
         .cmp_we (cmp_we[j]),
         .msk_we (msk_we[j]),
         .wdata  (reg_wdata),
         .tbc    (tbc_q),
         .cmp_q  (cmp_val[j]),
         .msk_q  (msk_val[j]),
         .hit    (cmp_hit[j])
      );
      assign irq_cmp[j] = sts_q[CMP_BIT0+j] & ien_q[CMP_BIT0+j] & ~imask_q[CMP_BIT0+j];
   end

   always_comb begin
      sts_set = '0;
      for (int i = 0; i < N_CAP; i++) sts_set[i] = cap_hit[i];
      for (int j = 0; j < N_CMP; j++) sts_set[CMP_BIT0+j] = cmp_hit[j];
   end

   assign sts_clr = (reg_we && reg_addr == A_ISTS) ? reg_wdata : '0;

   always_ff @(posedge clk) begin
      sts_q <= ((sts_q & ~sts_clr) | sts_set) & CH_BITS;
      if (reg_we && reg_addr == A_IEN) ien_q <= reg_wdata;
      if (unit_rst) begin
         cap_en_q <= '0;
         imask_q  <= IMASK_RST;
      end else if (reg_we) begin
         if (reg_addr == A_CAPEN) cap_en_q <= reg_wdata[N_CAP-1:0];
         if (reg_addr == A_IMASK) imask_q  <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_TBC:   reg_rdata = tbc_q;
         A_CAPEN: reg_rdata = REG_W'(cap_en_q);
         A_IMASK: reg_rdata = imask_q;
         A_ISTS:  reg_rdata = sts_q;
         A_IEN:   reg_rdata = ien_q;
         default: reg_rdata = '0;
      endcase
      for (int j = 0; j < N_CMP; j++) begin
         if (reg_addr == A_CMP_BASE + addr_t'(j)) reg_rdata = cmp_val[j];
         if (reg_addr == A_MSK_BASE + addr_t'(j)) reg_rdata = msk_val[j];
      end
      for (int i = 0; i < N_CAP; i++) begin
         if (reg_addr == A_CAP_BASE + addr_t'(i)) reg_rdata = cap_val[i];
      end
   end
endmodule

// File: rtl/mcct_chk.sv
module mcct_chk
   import mcct_pkg::*;
#(
   parameter int               TBC_W     = 32,
   parameter int               N_CAP     = 5,
   parameter int               N_CMP     = 5,
   parameter int               CMP_BIT0  = 16,
   parameter logic [TBC_W-1:0] IMASK_RST = 32'hF800F800
) (
   input logic                            clk,
   input logic                            unit_rst,
   input logic                            tbc_rst,
   input logic                            reg_we,
   input logic [ADDR_W-1:0]               reg_addr,
   input logic [TBC_W-1:0]                reg_wdata,
   input logic [TBC_W-1:0]                tbc,
   input logic [N_CAP-1:0]                cap_en,
   input logic [TBC_W-1:0]                imask,
   input logic [TBC_W-1:0]                sts,
   input logic [N_CAP-1:0][TBC_W-1:0]     cap_val,
   input logic [N_CAP-1:0]                irq_cap,
   input logic [N_CMP-1:0]                irq_cmp
);
   // R1
   tbc_inc_chk: assert property (@(posedge clk) disable iff (unit_rst)
      (!tbc_rst && !(reg_we && reg_addr == A_TBC)) |=> tbc == $past(tbc) + 1'b1);

   // R8
   unit_rst_vals_chk: assert property (@(posedge clk)
      unit_rst |=> (tbc == '0 && cap_en == '0 && imask == IMASK_RST));

   // R10
   tbc_rst_only_chk: assert property (@(posedge clk) disable iff (unit_rst)
      (tbc_rst && !reg_we) |=> (tbc == '0 && $stable(cap_en) && $stable(imask)));

   for (genvar i = 0; i < N_CAP; i++) begin : gen_cap_chk
      // R5
      cap_hold_chk: assert property (@(posedge clk) disable iff (unit_rst)
         !cap_en[i] |=> $stable(cap_val[i]));
      // R6
      cap_sticky_chk: assert property (@(posedge clk) disable iff (unit_rst)
         (sts[i] && !(reg_we && reg_addr == A_ISTS && reg_wdata[i])) |=> sts[i]);
      // R7
      cap_irq_src_chk: assert property (@(posedge clk) disable iff (unit_rst)
         !sts[i] |-> !irq_cap[i]);
   end

   for (genvar j = 0; j < N_CMP; j++) begin : gen_cmp_chk
      // R6
      cmp_sticky_chk: assert property (@(posedge clk) disable iff (unit_rst)
         (sts[CMP_BIT0+j] && !(reg_we && reg_addr == A_ISTS && reg_wdata[CMP_BIT0+j]))
         |=> sts[CMP_BIT0+j]);
      // R7
      cmp_irq_src_chk: assert property (@(posedge clk) disable iff (unit_rst)
         !sts[CMP_BIT0+j] |-> !irq_cmp[j]);
   end
endmodule

bind mcct_top mcct_chk #(
   .TBC_W(TBC_W), .N_CAP(N_CAP), .N_CMP(N_CMP), .CMP_BIT0(CMP_BIT0), .IMASK_RST(IMASK_RST)
) u_chk (
   .clk(clk), .unit_rst(unit_rst), .tbc_rst(tbc_rst), .reg_we(reg_we),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .tbc(tbc_q), .cap_en(cap_en_q),
   .imask(imask_q), .sts(sts_q), .cap_val(cap_val), .irq_cap(irq_cap), .irq_cmp(irq_cmp)
);

// File: tb/mcct_top_bench.sv
module mcct_top_bench;
   logic        clk = 1'b0;
   logic        unit_rst = 1'b1;
   logic        tbc_rst = 1'b0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = 6'h00;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic [4:0]  cap_in = 5'b0;
   logic [4:0]  irq_cap;
   logic [4:0]  irq_cmp;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   mcct_top u_mcct_top (
      .clk(clk), .unit_rst(unit_rst), .tbc_rst(tbc_rst), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cap_in(cap_in), .irq_cap(irq_cap), .irq_cmp(irq_cmp)
   );

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      logic [31:0] msk;
      string       tag;
   } item_t;
   item_t q[$];

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_rd(input logic [5:0] a, input logic [31:0] e,
                            input logic [31:0] m, input string tag);
      @(posedge clk); #1;
      reg_addr = a;
      q.push_back('{1'b0, e, m, tag});
   endtask

   task automatic expect_irq(input logic [9:0] e, input string tag);
      @(posedge clk); #1;
      q.push_back('{1'b1, {22'b0, e}, 32'h3FF, tag});
   endtask

   task automatic pulse_unit();
      @(posedge clk); #1 unit_rst = 1'b1;
      @(posedge clk); #1 unit_rst = 1'b0;
   endtask

   task automatic pulse_tbc();
      @(posedge clk); #1 tbc_rst = 1'b1;
      @(posedge clk); #1 tbc_rst = 1'b0;
   endtask

   always @(negedge clk) begin
      item_t it;
      logic [31:0] act;
      if (!done && q.size() > 0) begin
         it  = q.pop_front();
         act = it.is_irq ? {22'b0, irq_cmp, irq_cap} : reg_rdata;
         checks++;
         if ((act & it.msk) !== (it.exp & it.msk)) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", it.tag, act & it.msk, it.exp & it.msk);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      unit_rst = 1'b0;
      expect_rd(6'h00, 32'h1, 32'hFFFFFFFF, "R8 counter after reset");
      expect_rd(6'h02, 32'hF800F800, 32'hFFFFFFFF, "R8 mask reset value");
      expect_rd(6'h01, 32'h0, 32'hFFFFFFFF, "R8 capture enable reset");

      wr(6'h00, 32'hFFFFFFFF);
      expect_rd(6'h00, 32'h0, 32'hFFFFFFFF, "R1 wrap");
      wr(6'h00, 32'h100);
      expect_rd(6'h00, 32'h101, 32'hFFFFFFFF, "R1 load then count");

      // compare setup
      wr(6'h08, 32'hABCD0040); wr(6'h10, 32'h0);
      wr(6'h09, 32'hABCD0040); wr(6'h11, 32'hFFFF0000);
      wr(6'h0A, 32'h00001200); wr(6'h12, 32'h000000FF);
      wr(6'h0B, 32'h77777777); wr(6'h13, 32'h0);
      wr(6'h0C, 32'h77777777); wr(6'h14, 32'h0);
      wr(6'h04, 32'h0);
      wr(6'h03, 32'hFFFFFFFF);
      expect_rd(6'h03, 32'h0, 32'hFFFFFFFF, "R6 status cleared by W1C");

      wr(6'h00, 32'h12340030);
      idle(40);
      expect_rd(6'h03, 32'h00020000, 32'h001F0000, "R2 partial mask matches, exact does not");
      expect_rd(6'h03, 32'h00020000, 32'h001F0000, "R6 status sticky");
      wr(6'h03, 32'h00000000);
      expect_rd(6'h03, 32'h00020000, 32'h001F0000, "R6 write 0 keeps status");
      wr(6'h03, 32'h00030000);
      wr(6'h00, 32'hABCD0030);
      idle(40);
      expect_rd(6'h03, 32'h00030000, 32'h001F0000, "R2 full compare both fire");

      wr(6'h03, 32'hFFFFFFFF);
      wr(6'h00, 32'h000011FC);
      idle(12);
      expect_rd(6'h03, 32'h00040000, 32'h00040000, "R2 low-byte mask window");
      wr(6'h03, 32'h00040000);
      expect_rd(6'h03, 32'h0, 32'h00040000, "R3 persistent match no retrigger");

      // capture
      wr(6'h01, 32'h1);
      wr(6'h03, 32'h1);
      wr(6'h00, 32'h00005000);
      cap_in[0] = 1'b1;
      idle(8);
      expect_rd(6'h18, 32'h00005002, 32'hFFFFFFFF, "R4 capture value");
      expect_rd(6'h03, 32'h1, 32'h1, "R4 capture status");
      wr(6'h01, 32'h0);
      wr(6'h03, 32'h1);
      cap_in[0] = 1'b0;
      idle(5);
      cap_in[0] = 1'b1;
      idle(6);
      expect_rd(6'h18, 32'h00005002, 32'hFFFFFFFF, "R5 disabled capture keeps value");
      expect_rd(6'h03, 32'h0, 32'h1, "R5 disabled capture no status");

      // interrupt gating
      wr(6'h03, 32'hFFFFFFFF);
      wr(6'h00, 32'h000011FC);
      idle(12);
      wr(6'h04, 32'h00040000);
      expect_irq(10'b00100_00000, "R7 enabled unmasked line high");
      wr(6'h02, 32'hF804F800);
      expect_irq(10'b0, "R7 masked line low");
      wr(6'h02, 32'hF800F800);
      wr(6'h04, 32'h0);
      expect_irq(10'b0, "R7 disabled line low");

      // counter-only reset
      wr(6'h01, 32'h1F);
      wr(6'h02, 32'h12345678);
      pulse_tbc();
      expect_rd(6'h00, 32'h1, 32'hFFFFFFFF, "R10 counter cleared");
      expect_rd(6'h01, 32'h1F, 32'hFFFFFFFF, "R10 capture enable kept");
      expect_rd(6'h02, 32'h12345678, 32'hFFFFFFFF, "R10 mask kept");

      // unit reset
      wr(6'h04, 32'h000000AA);
      pulse_unit();
      expect_rd(6'h00, 32'h1, 32'hFFFFFFFF, "R8 counter cleared");
      expect_rd(6'h01, 32'h0, 32'hFFFFFFFF, "R8 capture enable cleared");
      expect_rd(6'h02, 32'hF800F800, 32'hFFFFFFFF, "R8 mask reloaded");
      expect_rd(6'h04, 32'h000000AA, 32'hFFFFFFFF, "R9 enable kept");
      expect_rd(6'h09, 32'hABCD0040, 32'hFFFFFFFF, "R9 compare kept");
      expect_rd(6'h11, 32'hFFFF0000, 32'hFFFFFFFF, "R9 compare mask kept");
      expect_rd(6'h18, 32'h00005002, 32'hFFFFFFFF, "R9 capture kept");

      idle(3);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule